// File: doc/BRIEF.md
# Two-Stage Address Translation Sequencer

This block steers the translation of a single memory access on a core that can host guest operating systems. When an access is accepted, the block looks at the current privilege level and at the virtualisation control bits. From these it decides whether the access is translated once, or twice: first through the guest's tables, then through the host's tables. It drives each lookup to an external page-table walker over a valid/ready request and a response strobe. With every lookup it sends a flag for a virtualised lookup and a flag for the first stage. After a two-stage lookup, the first-stage result becomes the input of the second stage.

When translation succeeds and memory protection is enabled, the final physical address goes to an external protection checker. The query carries the access size and a one-hot access type. The block then produces one of three results. A successful access gives a page-aligned fill for the TLB. A failed normal access gives a fault with a cause code, an address and an ownership flag. A failed probe access gives a miss. Only one access is in flight at a time, and `busy` covers it from acceptance to the result.

Top module: `two_stage_xlate_seq`

## Requirements
- R1: After reset, `busy` is 0, `req_ready` is 1, and `wk_req_valid`, `prot_valid`, `fill_valid`, `fault_valid` and `miss_valid` are all 0.
- R2: An access needs a single-stage lookup when none of the conditions in R3, R4 and R5 holds. It then makes exactly one walker request, on `req_vaddr`, with `wk_virt`=0 and `wk_first`=1.
- R3: With `virt_on`=1, the block makes two walker requests, both with `wk_virt`=1. The first is on `req_vaddr` with `wk_first`=1. The second is on the address returned by the first response, with `wk_first`=0.
- R4: With `hyp_en`=1 and `priv`=3 (machine), a two-stage lookup is used when the access is not a fetch and both `m_mod_priv` and `m_prev_virt` are 1. A fetch (`req_acc`=2) stays single-stage.
- R5: With `hyp_en`=1, `priv`=1 (supervisor) and `virt_on`=0, a two-stage lookup is used when the access is not a fetch and both `s_mod_priv` and `s_prev_virt` are 1.
- R6: With `hyp_en`=0, the bits `m_mod_priv`, `m_prev_virt`, `s_mod_priv` and `s_prev_virt` have no effect, and the lookup is single-stage unless `virt_on`=1.
- R7: A failed first-stage response ends the access at once, with no second request. The fault has `fault_cause`=1 (page), `fault_hyp`=0 and `fault_addr`=`req_vaddr`. A failed single-stage lookup is reported the same way.
- R8: A failed second-stage response gives `fault_cause`=1 and `fault_hyp`=1. The `fault_addr` is the intermediate address OR'ed with the low 12 bits of `req_vaddr`.
- R9: The protection checker is queried exactly once, and only when translation succeeded and `prot_en`=1. The query carries the final physical address, `req_size`, and `prot_acc` one-hot: bit0 load (`req_acc`=0), bit1 store (1), bit2 fetch (2). A denial gives `fault_cause`=2 (access). `fault_hyp` is then 1 for a two-stage access and 0 for a single-stage one, and the address follows R7 or R8 in the same way.
- R10: On success, `fill_va` and `fill_pa` are the virtual and final physical addresses with their low 12 bits cleared. `fill_perm` is the permission returned by the last lookup.
- R11: When `req_probe`=1, a failure of any kind raises `miss_valid` instead of `fault_valid`.
- R12: From the acceptance edge until the cycle after the result pulse, `busy` is 1 and `req_ready` is 0. A walker request stays valid with a steady address until `wk_req_ready`.
- R13: Each accepted access gives exactly one single-cycle pulse on exactly one of `fill_valid`, `fault_valid` or `miss_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block is idle and accepts an access |
| req_vaddr | input | ADDR_W | Virtual address |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| req_size | input | SIZE_W | Access size, passed to the protection query |
| req_probe | input | 1 | Probe access: failure reports a miss |
| priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| virt_on | input | 1 | Virtualisation mode active |
| hyp_en | input | 1 | Hypervisor support enabled |
| m_mod_priv | input | 1 | Machine-level modify-privilege bit |
| m_prev_virt | input | 1 | Machine-level previous-virtualisation bit |
| s_mod_priv | input | 1 | Hypervisor-status modify-privilege bit |
| s_prev_virt | input | 1 | Hypervisor-status previous-virtualisation bit |
| prot_en | input | 1 | Physical memory protection enabled |
| wk_req_valid | output | 1 | Walker lookup request |
| wk_req_ready | input | 1 | Walker accepts the request |
| wk_addr | output | ADDR_W | Address to translate |
| wk_virt | output | 1 | Lookup belongs to a two-stage translation |
| wk_first | output | 1 | Lookup is the first stage |
| wk_acc | output | 2 | Access type of the lookup |
| wk_rsp_valid | input | 1 | Walker response strobe |
| wk_rsp_ok | input | 1 | Lookup succeeded |
| wk_rsp_pa | input | ADDR_W | Translated address |
| wk_rsp_perm | input | PERM_W | Permission bits |
| prot_valid | output | 1 | Protection query in progress |
| prot_addr | output | ADDR_W | Final physical address |
| prot_size | output | SIZE_W | Access size |
| prot_acc | output | 3 | One-hot access type |
| prot_allow | input | 1 | Protection check passes |
| busy | output | 1 | Access in flight |
| fill_valid | output | 1 | Fill result pulse |
| fill_va | output | ADDR_W | Page-aligned virtual address |
| fill_pa | output | ADDR_W | Page-aligned physical address |
| fill_perm | output | PERM_W | Permission of the last lookup |
| fault_valid | output | 1 | Fault result pulse |
| fault_addr | output | ADDR_W | Reported fault address |
| fault_cause | output | 2 | 1 page fault, 2 access fault |
| fault_hyp | output | 1 | Fault owned by the hypervisor level |
| miss_valid | output | 1 | Probe miss pulse |

## Verification
The assertions rely on two things from the surrounding logic. The walker raises `wk_rsp_valid` only while a lookup it has accepted is outstanding, and `req_acc` never takes the unused code 3. The bench's walker model answers only after a handshake, with a single-cycle strobe, and the random stimulus draws access types from 0 to 2 only. The random mix covers privilege, the mode bits, stage failures, protection denials and probes. The directed cases cover the fetch exclusion, supervisor mode with virtualisation on, and every failure point combined with probe.

// File: rtl/tst_pkg.sv
package tst_pkg;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_PAGE   = 2'd1,
    CAUSE_ACCESS = 2'd2
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WREQ = 3'd1,
    ST_WRSP = 3'd2,
    ST_PROT = 3'd3,
    ST_DONE = 3'd4
  } st_e;
endpackage

// File: rtl/tst_mode_decode.sv
module tst_mode_decode
  import tst_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic [1:0] acc_i,
  input  logic       virt_on_i,
  input  logic       hyp_en_i,
  input  logic       m_mod_priv_i,
  input  logic       m_prev_virt_i,
  input  logic       s_mod_priv_i,
  input  logic       s_prev_virt_i,
  output logic       two_stage_o
);
  logic not_fetch;
  logic m_cond;
  logic s_cond;

  assign not_fetch   = (acc_i != ACC_FETCH);
  assign m_cond      = (priv_i == PRIV_M) && not_fetch && m_mod_priv_i && m_prev_virt_i;
  assign s_cond      = (priv_i == PRIV_S) && !virt_on_i && not_fetch &&
                       s_mod_priv_i && s_prev_virt_i;
  assign two_stage_o = virt_on_i || (hyp_en_i && (m_cond || s_cond));
endmodule

// File: rtl/tst_acc_onehot.sv
module tst_acc_onehot #(
  parameter int N = 3,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [CW-1:0] code_i,
  output logic [N-1:0]  hot_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign hot_o[i] = (code_i == CW'(i));
  end
endmodule

// File: rtl/tst_result_form.sv
module tst_result_form #(
  parameter int ADDR_W  = 40,
  parameter int PG_BITS = 12
) (
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [ADDR_W-1:0] im_i,
  input  logic [ADDR_W-1:0] pa_i,
  input  logic              hyp_i,
  output logic [ADDR_W-1:0] fill_va_o,
  output logic [ADDR_W-1:0] fill_pa_o,
  output logic [ADDR_W-1:0] fault_addr_o
);
  localparam logic [ADDR_W-1:0] OFF_MASK = {{(ADDR_W-PG_BITS){1'b0}}, {PG_BITS{1'b1}}};

  assign fill_va_o    = vaddr_i & ~OFF_MASK;
  assign fill_pa_o    = pa_i & ~OFF_MASK;
  assign fault_addr_o = hyp_i ? (im_i | (vaddr_i & OFF_MASK)) : vaddr_i;
endmodule

// File: rtl/two_stage_xlate_seq.sv
module two_stage_xlate_seq
  import tst_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int PG_BITS = 12,
  parameter int SIZE_W  = 4,
  parameter int PERM_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_probe,
  input  logic [1:0]        priv,
  input  logic              virt_on,
  input  logic              hyp_en,
  input  logic              m_mod_priv,
  input  logic              m_prev_virt,
  input  logic              s_mod_priv,
  input  logic              s_prev_virt,
  input  logic              prot_en,
  output logic              wk_req_valid,
  input  logic              wk_req_ready,
  output logic [ADDR_W-1:0] wk_addr,
  output logic              wk_virt,
  output logic              wk_first,
  output logic [1:0]        wk_acc,
  input  logic              wk_rsp_valid,
  input  logic              wk_rsp_ok,
  input  logic [ADDR_W-1:0] wk_rsp_pa,
  input  logic [PERM_W-1:0] wk_rsp_perm,
  output logic              prot_valid,
  output logic [ADDR_W-1:0] prot_addr,
  output logic [SIZE_W-1:0] prot_size,
  output logic [2:0]        prot_acc,
  input  logic              prot_allow,
  output logic              busy,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_va,
  output logic [ADDR_W-1:0] fill_pa,
  output logic [PERM_W-1:0] fill_perm,
  output logic              fault_valid,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [1:0]        fault_cause,
  output logic              fault_hyp,
  output logic              miss_valid
);
  st_e               state_q, state_d;
  logic [ADDR_W-1:0] vaddr_q, im_q, pa_q;
  logic [ADDR_W-1:0] im_d, pa_d;
  logic [1:0]        acc_q;
  logic [SIZE_W-1:0] size_q;
  logic [PERM_W-1:0] perm_q, perm_d;
  logic              probe_q, two_q, prot_en_q, stage2_q, stage2_d;
  logic              ok_q, ok_d, hyp_q, hyp_d;
  cause_e            cause_q, cause_d;
  logic              two_stage;
  logic              cap_en;

  tst_mode_decode u_decode (
    .priv_i        (priv),
    .acc_i         (req_acc),
    .virt_on_i     (virt_on),
    .hyp_en_i      (hyp_en),
    .m_mod_priv_i  (m_mod_priv),
    .m_prev_virt_i (m_prev_virt),
    .s_mod_priv_i  (s_mod_priv),
    .s_prev_virt_i (s_prev_virt),
    .two_stage_o   (two_stage)
  );

  tst_acc_onehot #(.N(3)) u_onehot (
    .code_i (acc_q),
    .hot_o  (prot_acc)
  );

  tst_result_form #(.ADDR_W(ADDR_W), .PG_BITS(PG_BITS)) u_form (
    .vaddr_i      (vaddr_q),
    .im_i         (im_q),
    .pa_i         (pa_q),
    .hyp_i        (hyp_q),
    .fill_va_o    (fill_va),
    .fill_pa_o    (fill_pa),
    .fault_addr_o (fault_addr)
  );

  assign cap_en = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d  = state_q;
    stage2_d = stage2_q;
    im_d     = im_q;
    pa_d     = pa_q;
    perm_d   = perm_q;
    ok_d     = ok_q;
    hyp_d    = hyp_q;
    cause_d  = cause_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        state_d  = ST_WREQ;
        stage2_d = 1'b0;
        ok_d     = 1'b0;
        hyp_d    = 1'b0;
        cause_d  = CAUSE_NONE;
      end
      ST_WREQ: if (wk_req_ready) state_d = ST_WRSP;
      ST_WRSP: if (wk_rsp_valid) begin
        if (!wk_rsp_ok) begin
          cause_d = CAUSE_PAGE;
          hyp_d   = stage2_q;
          state_d = ST_DONE;
        end else if (two_q && !stage2_q) begin
          im_d     = wk_rsp_pa;
          stage2_d = 1'b1;
          state_d  = ST_WREQ;
        end else begin
          pa_d    = wk_rsp_pa;
          perm_d  = wk_rsp_perm;
          ok_d    = !prot_en_q;
          state_d = prot_en_q ? ST_PROT : ST_DONE;
        end
      end
      ST_PROT: begin
        ok_d    = prot_allow;
        cause_d = prot_allow ? CAUSE_NONE : CAUSE_ACCESS;
        hyp_d   = !prot_allow && stage2_q;
        state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      vaddr_q   <= '0;
      acc_q     <= '0;
      size_q    <= '0;
      probe_q   <= 1'b0;
      two_q     <= 1'b0;
      prot_en_q <= 1'b0;
      stage2_q  <= 1'b0;
      im_q      <= '0;
      pa_q      <= '0;
      perm_q    <= '0;
      ok_q      <= 1'b0;
      hyp_q     <= 1'b0;
      cause_q   <= CAUSE_NONE;
    end else begin
      state_q  <= state_d;
      stage2_q <= stage2_d;
      im_q     <= im_d;
      pa_q     <= pa_d;
      perm_q   <= perm_d;
      ok_q     <= ok_d;
      hyp_q    <= hyp_d;
      cause_q  <= cause_d;
      if (cap_en) begin
        vaddr_q   <= req_vaddr;
        acc_q     <= req_acc;
        size_q    <= req_size;
        probe_q   <= req_probe;
        two_q     <= two_stage;
        prot_en_q <= prot_en;
      end
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign busy         = (state_q != ST_IDLE);
  assign wk_req_valid = (state_q == ST_WREQ);
  assign wk_addr      = stage2_q ? im_q : vaddr_q;
  assign wk_virt      = two_q;
  assign wk_first     = !stage2_q;
  assign wk_acc       = acc_q;
  assign prot_valid   = (state_q == ST_PROT);
  assign prot_addr    = pa_q;
  assign prot_size    = size_q;
  assign fill_valid   = (state_q == ST_DONE) && ok_q;
  assign fill_perm    = perm_q;
  assign fault_valid  = (state_q == ST_DONE) && !ok_q && !probe_q;
  assign miss_valid   = (state_q == ST_DONE) && !ok_q && probe_q;
  assign fault_cause  = cause_q;
  assign fault_hyp    = hyp_q;
endmodule

// File: rtl/tst_chk.sv
module tst_chk #(
  parameter int ADDR_W  = 40,
  parameter int PG_BITS = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              wk_req_valid,
  input logic              wk_req_ready,
  input logic [ADDR_W-1:0] wk_addr,
  input logic              wk_virt,
  input logic              wk_first,
  input logic              prot_valid,
  input logic [2:0]        prot_acc,
  input logic              fill_valid,
  input logic [ADDR_W-1:0] fill_va,
  input logic [ADDR_W-1:0] fill_pa,
  input logic              fault_valid,
  input logic [1:0]        fault_cause,
  input logic              miss_valid
);
  // R12
  wk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wk_req_valid && !wk_req_ready |=> wk_req_valid && $stable(wk_addr) && $stable(wk_first));

  // R12
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready);

  // R13
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fill_valid, fault_valid, miss_valid}));

  // R13
  result_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid || fault_valid || miss_valid) |=> !busy && !fill_valid && !fault_valid && !miss_valid);

  // R10
  fill_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (fill_va[PG_BITS-1:0] == '0) && (fill_pa[PG_BITS-1:0] == '0));

  // R9
  prot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_valid |-> $countones(prot_acc) == 1);

  // R3
  second_virt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wk_req_valid && !wk_first |-> wk_virt);

  // R7
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (fault_cause == 2'd1) || (fault_cause == 2'd2));
endmodule

bind two_stage_xlate_seq tst_chk #(.ADDR_W(ADDR_W), .PG_BITS(PG_BITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .busy         (busy),
  .wk_req_valid (wk_req_valid),
  .wk_req_ready (wk_req_ready),
  .wk_addr      (wk_addr),
  .wk_virt      (wk_virt),
  .wk_first     (wk_first),
  .prot_valid   (prot_valid),
  .prot_acc     (prot_acc),
  .fill_valid   (fill_valid),
  .fill_va      (fill_va),
  .fill_pa      (fill_pa),
  .fault_valid  (fault_valid),
  .fault_cause  (fault_cause),
  .miss_valid   (miss_valid)
);

// File: tb/two_stage_xlate_seq_tb.sv
module two_stage_xlate_seq_tb;
  localparam int AW = 40;
  localparam int SW = 4;
  localparam int PW = 3;
  localparam logic [PW-1:0] P1 = 3'b011;
  localparam logic [PW-1:0] P2 = 3'b110;

  logic clk, rst_n;
  logic req_valid, req_ready, req_probe;
  logic [AW-1:0] req_vaddr;
  logic [1:0] req_acc, priv;
  logic [SW-1:0] req_size;
  logic virt_on, hyp_en, m_mod_priv, m_prev_virt, s_mod_priv, s_prev_virt, prot_en;
  logic wk_req_valid, wk_req_ready, wk_virt, wk_first, wk_rsp_valid, wk_rsp_ok;
  logic [AW-1:0] wk_addr, wk_rsp_pa;
  logic [1:0] wk_acc;
  logic [PW-1:0] wk_rsp_perm;
  logic prot_valid, prot_allow;
  logic [AW-1:0] prot_addr;
  logic [SW-1:0] prot_size;
  logic [2:0] prot_acc;
  logic busy, fill_valid, fault_valid, fault_hyp, miss_valid;
  logic [AW-1:0] fill_va, fill_pa, fault_addr;
  logic [PW-1:0] fill_perm;
  logic [1:0] fault_cause;

  two_stage_xlate_seq u_dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit cfg_f1, cfg_f2, cfg_deny;
  int wn, pn;
  logic [AW-1:0] w_addr [4];
  logic w_virt [4], w_first [4];
  logic [AW-1:0] p_addr;
  logic [2:0] p_acc;
  logic [SW-1:0] p_size;
  logic [AW-1:0] cur_addr;
  logic cur_first;

  assign prot_allow = !cfg_deny;

  function automatic logic [AW-1:0] map1(logic [AW-1:0] a);
    return AW'((a >> 12) ^ 40'h00_00A5_C3F1) << 12;
  endfunction
  function automatic logic [AW-1:0] map2(logic [AW-1:0] a);
    return AW'((a >> 12) + 40'h00_0012_3457) << 12;
  endfunction

  task automatic chk(bit c, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // walker model
  initial begin
    wk_req_ready = 0; wk_rsp_valid = 0; wk_rsp_ok = 0; wk_rsp_pa = '0; wk_rsp_perm = '0;
    forever begin
      @(negedge clk);
      wk_rsp_valid = 0;
      if (wk_req_ready) begin
        wk_req_ready = 0;
        wk_rsp_valid = 1;
        wk_rsp_ok    = cur_first ? !cfg_f1 : !cfg_f2;
        wk_rsp_pa    = cur_first ? map1(cur_addr) : map2(cur_addr);
        wk_rsp_perm  = cur_first ? P1 : P2;
      end else if (rst_n && wk_req_valid) begin
        cur_addr = wk_addr; cur_first = wk_first;
        if (wn < 4) begin w_addr[wn] = wk_addr; w_virt[wn] = wk_virt; w_first[wn] = wk_first; end
        wn++;
        wk_req_ready = 1;
      end
    end
  end

  // protection monitor
  always @(negedge clk) if (rst_n && prot_valid) begin
    pn++; p_addr = prot_addr; p_acc = prot_acc; p_size = prot_size;
  end

  task automatic run_one();
    bit two, tok, ok, hyp;
    logic [AW-1:0] im, fpa, faddr;
    string mt;
    int got = 0, kind = 0;
    logic [AW-1:0] r_va = '0, r_pa = '0, r_fa = '0;
    logic [PW-1:0] r_perm = '0;
    logic [1:0] r_cause = '0;
    logic r_hyp = 0;
    two = virt_on || (hyp_en && ((priv == 2'd3 && req_acc != 2'd2 && m_mod_priv && m_prev_virt) ||
                                 (priv == 2'd1 && !virt_on && req_acc != 2'd2 && s_mod_priv && s_prev_virt)));
    im  = map1(req_vaddr);
    tok = two ? (!cfg_f1 && !cfg_f2) : !cfg_f1;
    fpa = two ? map2(im) : map1(req_vaddr);
    ok  = tok && !(prot_en && cfg_deny);
    hyp = two && !cfg_f1;
    faddr = hyp ? (im | {28'd0, req_vaddr[11:0]}) : req_vaddr;
    if (two && virt_on) mt = "R3";
    else if (two && priv == 2'd3) mt = "R4";
    else if (two) mt = "R5";
    else if (!hyp_en) mt = "R6";
    else mt = "R2";
    wn = 0; pn = 0;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(busy && !req_ready, "R12 busy after accept", {busy, req_ready}, 2'b10);
    for (int i = 0; i < 60 && got == 0; i++) begin
      if (fill_valid || fault_valid || miss_valid) begin
        got = 1;
        kind = fill_valid ? 1 : (fault_valid ? 2 : 3);
        chk($countones({fill_valid, fault_valid, miss_valid}) == 1, "R13 single result",
            {fill_valid, fault_valid, miss_valid}, 1);
        r_va = fill_va; r_pa = fill_pa; r_perm = fill_perm; r_fa = fault_addr;
        r_cause = fault_cause; r_hyp = fault_hyp;
        if (!busy) chk(0, "R12 busy during result", busy, 1);
      end else @(negedge clk);
    end
    chk(got == 1, "R13 result seen", got, 1);
    @(negedge clk);
    chk(!fill_valid && !fault_valid && !miss_valid && !busy && req_ready, "R13 pulse ends",
        {fill_valid, fault_valid, miss_valid, busy, req_ready}, 5'b00001);
    chk(wn == ((two && !cfg_f1) ? 2 : 1), {mt, " walk count"}, wn, (two && !cfg_f1) ? 2 : 1);
    chk(w_addr[0] == req_vaddr && w_virt[0] == two && w_first[0], {mt, " first walk"},
        {w_addr[0], w_virt[0], w_first[0]}, {req_vaddr, two, 1'b1});
    if (two && !cfg_f1)
      chk(w_addr[1] == im && w_virt[1] && !w_first[1], "R3 second walk",
          {w_addr[1], w_virt[1], w_first[1]}, {im, 2'b10});
    chk(pn == ((tok && prot_en) ? 1 : 0), "R9 query count", pn, (tok && prot_en) ? 1 : 0);
    if (tok && prot_en)
      chk(p_addr == fpa && p_acc == (3'b001 << req_acc) && p_size == req_size, "R9 query fields",
          {p_addr, p_acc, p_size}, {fpa, 3'b001 << req_acc, req_size});
    if (ok) begin
      chk(kind == 1, "R10 fill expected", kind, 1);
      chk(r_va == {req_vaddr[AW-1:12], 12'd0} && r_pa == {fpa[AW-1:12], 12'd0} &&
          r_perm == (two ? P2 : P1), "R10 fill values", {r_va, r_pa}, {req_vaddr, fpa});
    end else if (req_probe) begin
      chk(kind == 3, "R11 miss expected", kind, 3);
    end else begin
      chk(kind == 2, "R7 fault expected", kind, 2);
      chk(r_cause == (tok ? 2'd2 : 2'd1), tok ? "R9 cause" : "R7 cause", r_cause, tok ? 2 : 1);
      chk(r_hyp == hyp && r_fa == faddr, hyp ? "R8 owner/addr" : "R7 owner/addr",
          {r_hyp, r_fa}, {hyp, faddr});
    end
  endtask

  task automatic setm(logic [1:0] p, bit v, bit h, bit mp, bit mv, bit sp, bit sv);
    priv = p; virt_on = v; hyp_en = h;
    m_mod_priv = mp; m_prev_virt = mv; s_mod_priv = sp; s_prev_virt = sv;
  endtask

  task automatic setr(logic [AW-1:0] va, logic [1:0] acc, bit pr, bit pe, bit f1, bit f2, bit dn);
    req_vaddr = va; req_acc = acc; req_probe = pr; prot_en = pe;
    req_size = SW'(acc + 1);
    cfg_f1 = f1; cfg_f2 = f2; cfg_deny = dn;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R12 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0;
    setm(2'd0, 0, 0, 0, 0, 0, 0);
    setr('0, 2'd0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(!busy && req_ready && !wk_req_valid && !prot_valid && !fill_valid && !fault_valid && !miss_valid,
        "R1 reset state", {busy, req_ready, wk_req_valid}, 3'b010);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && req_ready, "R1 after release", {busy, req_ready}, 2'b01);
    // R2 plain user single-stage success
    setm(2'd0, 0, 1, 0, 0, 0, 0); setr(40'h12_3456_7ABC, 2'd0, 0, 0, 0, 0, 0); run_one();
    // R3 virtualised, success with protection
    setm(2'd1, 1, 1, 0, 0, 0, 0); setr(40'hAB_CDEF_0123, 2'd1, 0, 1, 0, 0, 0); run_one();
    // R4 machine two-stage, then fetch stays single
    setm(2'd3, 0, 1, 1, 1, 0, 0); setr(40'h01_0000_0FFF, 2'd1, 0, 0, 0, 0, 0); run_one();
    setm(2'd3, 0, 1, 1, 1, 0, 0); setr(40'h01_0000_0FFF, 2'd2, 0, 0, 0, 0, 0); run_one();
    // R5 supervisor two-stage; with virt on it is two-stage through R3 anyway
    setm(2'd1, 0, 1, 0, 0, 1, 1); setr(40'h77_0000_1234, 2'd0, 0, 1, 0, 0, 0); run_one();
    // R6 bits ignored without hypervisor support
    setm(2'd3, 0, 0, 1, 1, 1, 1); setr(40'h55_5555_5555, 2'd1, 0, 0, 0, 0, 0); run_one();
    setm(2'd1, 0, 0, 1, 1, 1, 1); setr(40'h66_6666_6666, 2'd0, 0, 0, 0, 0, 0); run_one();
    // R7 first-stage failure
    setm(2'd0, 1, 1, 0, 0, 0, 0); setr(40'h00_BEEF_0ABC, 2'd0, 0, 1, 1, 0, 0); run_one();
    // R8 second-stage failure
    setm(2'd0, 1, 1, 0, 0, 0, 0); setr(40'h00_BEEF_0ABC, 2'd1, 0, 1, 0, 1, 0); run_one();
    // R9 denial single and two-stage
    setm(2'd0, 0, 1, 0, 0, 0, 0); setr(40'h10_2030_4050, 2'd2, 0, 1, 0, 0, 1); run_one();
    setm(2'd0, 1, 1, 0, 0, 0, 0); setr(40'h10_2030_4050, 2'd0, 0, 1, 0, 0, 1); run_one();
    // R11 probes at each failure point
    setm(2'd0, 1, 1, 0, 0, 0, 0); setr(40'h31_0000_0001, 2'd0, 1, 1, 1, 0, 0); run_one();
    setm(2'd0, 1, 1, 0, 0, 0, 0); setr(40'h32_0000_0002, 2'd0, 1, 1, 0, 1, 0); run_one();
    setm(2'd0, 1, 1, 0, 0, 0, 0); setr(40'h33_0000_0003, 2'd1, 1, 1, 0, 0, 1); run_one();
    setm(2'd0, 0, 1, 0, 0, 0, 0); setr(40'h34_0000_0004, 2'd1, 1, 0, 0, 0, 0); run_one();
    // random mix
    void'($urandom(32'd4711));
    for (int n = 0; n < 250; n++) begin
      logic [1:0] pv;
      logic [63:0] rv;
      pv = ($urandom % 3 == 0) ? 2'd0 : (($urandom % 2) ? 2'd1 : 2'd3);
      rv = {$urandom, $urandom};
      setm(pv, ($urandom % 3) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
           $urandom % 2, $urandom % 2);
      setr(rv[AW-1:0], 2'($urandom % 3), ($urandom % 4) == 0, $urandom % 2,
           ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0);
      run_one();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule